// File: doc/BRIEF.md
# Multi-channel wait/hold PWM controller

This block generates seven independent pulse-width-modulated outputs from one register-mapped controller. Each channel chooses one of five source clocks, which arrive as single-cycle enable strobes in the system clock domain. The channel counts a programmable number of source ticks with its output high, then a programmable number with its output low, and repeats. A per-channel bypass mode instead passes the selected source strobe straight to the output, which turns the channel into a clock forwarder.

Three independent gates shape each channel: a pre-divider enable that lets source ticks reach the counter, a post-divider enable that releases the counter from its start state, and an output enable. Software reaches everything through a 32-bit single-cycle write port and a combinational read port. Phase counts are stored minus one, and new counts are picked up only at the end of a low phase, so a running waveform never shows a torn period. The source selection of a channel is locked while its pre-divider enable is set.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads as zero and every output is low; the counters start in the high phase with a count of zero.
- R2: Register map (byte addresses): 0x00 select (bits [3n+2:3n] source index of channel n, bit 21+n bypass of channel n), 0x04 output control (bit n output enable, bit 7+n transition-mode flag, stored and read back), 0x08 pre-divider enables (bit n), 0x0C post-divider enables (bit n), 0x10+8n high count of channel n and 0x14+8n low count of channel n (bits [15:0]). Reads return the stored fields; unused bits and unmapped addresses read as zero.
- R3: With all three gates set and bypass clear, the output is high for (high count + 1) ticks of the selected source and then low for (low count + 1) ticks, repeating. A source index of 5, 6 or 7 delivers no ticks, so the counter never advances.
- R4: New high and low counts take effect only when the low phase of the current period ends.
- R5: With bypass set and all three gates set, the output equals the selected source strobe in the same cycle.
- R6: A write to the select register leaves the source index of any channel whose pre-divider enable is set unchanged; the bypass bits are written regardless.
- R7: While the pre-divider enable of a channel is clear, its counter holds its state and its output is low; counting resumes from that state when the enable returns.
- R8: While the post-divider enable of a channel is clear, its counter is held in the start state (high phase, count zero) and its output is low; the output is high in the first cycle after the enable is set again.
- R9: While the output enable of a channel is clear, its output is low.
- R10: Channels run independently: each uses only its own source, counts and gates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Byte address for reads and writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| srcTick | input | 5 | Source clock strobes, one per source |
| pwmOut | output | 7 | Channel outputs (channels 0 to 5 external, 6 internal) |

## Verification
Assertions watch, on every cycle, that a channel with its post-divider enable clear sits in the start state, that the running count never passes the limit of its phase, that the latched period counts move only at a period boundary or while frozen, that a paused channel keeps its state, that the source index of a pre-enabled channel is frozen, and that a gate write lands in its register. Only the bench scenarios can show the whole waveform: the length of high and low runs for different sources, when a new count first appears, bypass forwarding, the read-back map, and the interaction of channels that share no settings; a behavioural per-cycle model compares all seven outputs throughout.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int PHASE_W = 16;

  // Per-channel strobes and limits handed from the register block to a channel.
  typedef struct packed {
    logic               run;       // post-divider enable: counter released
    logic               tickEn;    // a counted source tick this cycle
    logic               srcLevel;  // selected source strobe (for bypass)
    logic               bypass;    // forward source instead of waveform
    logic               outEn;     // all gates open for the pin
    logic [PHASE_W-1:0] highLim;   // high count minus one
    logic [PHASE_W-1:0] lowLim;    // low count minus one
  } chanCtrl_t;

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH  = 7,
  parameter int NUM_SRC = 5,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [NUM_SRC-1:0] srcTick,
  output chanCtrl_t         ctrl [NUM_CH]
);

  localparam int SEL_W     = 3;
  localparam int PAD_W     = 1 << SEL_W;
  localparam int BYP_BASE  = SEL_W * NUM_CH;
  localparam int MODE_BASE = NUM_CH;
  localparam int HI_BASE   = 16;
  localparam int LO_BASE   = 20;
  localparam int STRIDE    = 8;
  localparam logic [ADDR_W-1:0] ADDR_SEL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_OUT  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ADDR_PRE  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] ADDR_POST = ADDR_W'(12);

  logic [SEL_W-1:0]   selQ [NUM_CH];
  logic [PHASE_W-1:0] hiQ  [NUM_CH];
  logic [PHASE_W-1:0] loQ  [NUM_CH];
  logic [NUM_CH-1:0]  bypQ, oeQ, modeQ, preQ, postQ;
  logic [NUM_CH-1:0]  hiHit, loHit;
  logic [PAD_W-1:0]   srcPad;

  assign srcPad = PAD_W'(srcTick);

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      hiHit[c] = (addr == ADDR_W'(HI_BASE + STRIDE * c));
      loHit[c] = (addr == ADDR_W'(LO_BASE + STRIDE * c));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        selQ[c] <= '0;
        hiQ[c]  <= '0;
        loQ[c]  <= '0;
      end
      bypQ  <= '0;
      oeQ   <= '0;
      modeQ <= '0;
      preQ  <= '0;
      postQ <= '0;
    end else if (wrEn) begin
      if (addr == ADDR_SEL) begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (!preQ[c]) selQ[c] <= wrData[SEL_W*c +: SEL_W];
          bypQ[c] <= wrData[BYP_BASE + c];
        end
      end
      if (addr == ADDR_OUT) begin
        oeQ   <= wrData[NUM_CH-1:0];
        modeQ <= wrData[MODE_BASE +: NUM_CH];
      end
      if (addr == ADDR_PRE)  preQ  <= wrData[NUM_CH-1:0];
      if (addr == ADDR_POST) postQ <= wrData[NUM_CH-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        if (hiHit[c]) hiQ[c] <= wrData[PHASE_W-1:0];
        if (loHit[c]) loQ[c] <= wrData[PHASE_W-1:0];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_SEL) begin
      for (int c = 0; c < NUM_CH; c++) begin
        rdData[SEL_W*c +: SEL_W] = selQ[c];
        rdData[BYP_BASE + c]     = bypQ[c];
      end
    end
    if (addr == ADDR_OUT) begin
      rdData[NUM_CH-1:0]         = oeQ;
      rdData[MODE_BASE +: NUM_CH] = modeQ;
    end
    if (addr == ADDR_PRE)  rdData[NUM_CH-1:0] = preQ;
    if (addr == ADDR_POST) rdData[NUM_CH-1:0] = postQ;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hiHit[c]) rdData[PHASE_W-1:0] = hiQ[c];
      if (loHit[c]) rdData[PHASE_W-1:0] = loQ[c];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCtrl
    logic lvl;
    assign lvl               = srcPad[selQ[g]];
    assign ctrl[g].run       = postQ[g];
    assign ctrl[g].srcLevel  = lvl;
    assign ctrl[g].tickEn    = lvl & preQ[g] & postQ[g];
    assign ctrl[g].bypass    = bypQ[g];
    assign ctrl[g].outEn     = oeQ[g] & preQ[g] & postQ[g];
    assign ctrl[g].highLim   = hiQ[g];
    assign ctrl[g].lowLim    = loQ[g];

    // R6: source index frozen while pre-divider enable is set
    assert_sel_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      preQ[g] |=> $stable(selQ[g]));
  end

  // R2: a gate write lands in the register
  assert_pre_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == ADDR_PRE) |=> (preQ == $past(wrData[NUM_CH-1:0])));

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  chanCtrl_t ctrl,
  output logic      outLine
);

  logic               phaseHigh;
  logic [PHASE_W-1:0] cnt;
  logic [PHASE_W-1:0] shHi, shLo;
  logic               periodEnd;

  assign periodEnd = ctrl.tickEn && !phaseHigh && (cnt == shLo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseHigh <= 1'b1;
      cnt       <= '0;
      shHi      <= '0;
      shLo      <= '0;
    end else if (!ctrl.run) begin
      phaseHigh <= 1'b1;
      cnt       <= '0;
      shHi      <= ctrl.highLim;
      shLo      <= ctrl.lowLim;
    end else if (ctrl.tickEn) begin
      if (phaseHigh) begin
        if (cnt == shHi) begin
          phaseHigh <= 1'b0;
          cnt       <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (periodEnd) begin
        phaseHigh <= 1'b1;
        cnt       <= '0;
        shHi      <= ctrl.highLim;
        shLo      <= ctrl.lowLim;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign outLine = ctrl.outEn & (ctrl.bypass ? ctrl.srcLevel : phaseHigh);

  // R8: frozen channel sits in the start state
  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run |=> (phaseHigh && cnt == '0));

  // R3: count stays within the limit of its phase
  assert_hi_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phaseHigh |-> (cnt <= shHi));
  assert_lo_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !phaseHigh |-> (cnt <= shLo));

  // R4: latched counts move only at a period boundary
  assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && !periodEnd) |=> ($stable(shHi) && $stable(shLo)));

  // R7: no tick, running channel keeps its state
  assert_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && !ctrl.tickEn) |=> ($stable(cnt) && $stable(phaseHigh)));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH  = 7,
  parameter int NUM_SRC = 5,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_SRC-1:0] srcTick,
  output logic [NUM_CH-1:0]  pwmOut
);

  chanCtrl_t chanCtrl [NUM_CH];

  pwm_bank_regs #(
    .NUM_CH (NUM_CH),
    .NUM_SRC(NUM_SRC),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (regWrEn),
    .addr   (regAddr),
    .wrData (regWrData),
    .rdData (regRdData),
    .srcTick(srcTick),
    .ctrl   (chanCtrl)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    pwm_bank_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctrl   (chanCtrl[g]),
      .outLine(pwmOut[g])
    );
  end

endmodule

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [4:0]  srcTick = '0;
  logic [6:0]  pwmOut;

  int checks = 0;
  int bad = 0;
  bit modelOn = 0;
  bit finished = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  pwm_bank u_dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .srcTick(srcTick),
    .pwmOut(pwmOut)
  );

  // Source strobes: every cycle, every 2nd, every 3rd, random, every 5th
  always @(posedge clk) begin
    cyc <= cyc + 1;
    srcTick <= {((cyc + 1) % 5 == 0), 1'($urandom % 2),
                ((cyc + 1) % 3 == 0), ((cyc + 1) % 2 == 0), 1'b1};
  end

  // Behavioural reference model
  int mSel[7], mHi[7], mLo[7], mCnt[7], mShH[7], mShL[7];
  bit mByp[7], mOe[7], mPre[7], mPost[7], mPhase[7];

  function automatic bit srcLvl(int c);
    return (mSel[c] < 5) ? srcTick[mSel[c]] : 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 7; c++) begin
        mSel[c] = 0; mHi[c] = 0; mLo[c] = 0; mCnt[c] = 0; mShH[c] = 0; mShL[c] = 0;
        mByp[c] = 0; mOe[c] = 0; mPre[c] = 0; mPost[c] = 0; mPhase[c] = 1;
      end
    end else begin
      for (int c = 0; c < 7; c++) begin
        if (!mPost[c]) begin
          mPhase[c] = 1; mCnt[c] = 0; mShH[c] = mHi[c]; mShL[c] = mLo[c];
        end else if (mPre[c] && srcLvl(c)) begin
          if (mPhase[c]) begin
            if (mCnt[c] == mShH[c]) begin mPhase[c] = 0; mCnt[c] = 0; end
            else mCnt[c]++;
          end else begin
            if (mCnt[c] == mShL[c]) begin
              mPhase[c] = 1; mCnt[c] = 0; mShH[c] = mHi[c]; mShL[c] = mLo[c];
            end else mCnt[c]++;
          end
        end
      end
      if (regWrEn) begin
        for (int c = 0; c < 7; c++) begin
          if (regAddr == 8'h00) begin
            if (!mPre[c]) mSel[c] = (regWrData >> (3 * c)) & 7;
            mByp[c] = regWrData[21 + c];
          end
          if (regAddr == 8'h04) mOe[c] = regWrData[c];
          if (regAddr == 8'h08) mPre[c] = regWrData[c];
          if (regAddr == 8'h0C) mPost[c] = regWrData[c];
          if (regAddr == 8'(16 + 8 * c)) mHi[c] = regWrData[15:0];
          if (regAddr == 8'(20 + 8 * c)) mLo[c] = regWrData[15:0];
        end
      end
    end
  end

  // Per-cycle comparison of all outputs (R3, R10 and every gating rule)
  always @(negedge clk) begin
    if (modelOn && !finished) begin
      logic [6:0] exp;
      for (int c = 0; c < 7; c++)
        exp[c] = mOe[c] & mPre[c] & mPost[c] & (mByp[c] ? srcLvl(c) : mPhase[c]);
      checks++;
      if (pwmOut !== exp) begin
        bad++;
        $display("FAIL R3/R10 per-cycle model at cycle %0d: act=%b exp=%b", cyc, pwmOut, exp);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic measureRun(int ch, output int hl, output int ll);
    @(negedge clk);
    while (pwmOut[ch] !== 1'b0) @(negedge clk);
    while (pwmOut[ch] !== 1'b1) @(negedge clk);
    hl = 0;
    while (pwmOut[ch] === 1'b1) begin hl++; @(negedge clk); end
    ll = 0;
    while (pwmOut[ch] === 1'b0) begin ll++; @(negedge clk); end
  endtask

  logic [31:0] selImg, gateImg, rv;

  initial begin
    int hl, ll;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    modelOn = 1;

    // R1: reset state
    for (int a = 0; a < 72; a += 4) begin
      rd(8'(a), rv);
      chk("R1 reset read", rv, 32'h0);
    end
    chk("R1 outputs low", 32'(pwmOut), 32'h0);

    // R2: read back, field widths, unmapped addresses
    wr(8'h20, 32'hABCD_1234);
    rd(8'h20, rv); chk("R2 high count ch2 readback", rv, 32'h0000_1234);
    wr(8'h04, 32'hFFFF_3F80);
    rd(8'h04, rv); chk("R2 mode flags readback", rv, 32'h0000_3F80);
    wr(8'h04, 32'h0);
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h4C, rv); chk("R2 unmapped 0x4C", rv, 32'h0);
    rd(8'h80, rv); chk("R2 unmapped 0x80", rv, 32'h0);

    // R3 / R10: ch0 on source 0 (2,1), ch2 on source 2 (1,0)
    selImg = (32'd2 << 6);
    wr(8'h00, selImg);
    wr(8'h10, 32'd2); wr(8'h14, 32'd1);
    wr(8'h20, 32'd1); wr(8'h24, 32'd0);
    gateImg = 32'b101;
    wr(8'h0C, gateImg); wr(8'h08, gateImg); wr(8'h04, gateImg);
    measureRun(0, hl, ll);
    chk("R3 ch0 high run", hl, 3); chk("R3 ch0 low run", ll, 2);
    measureRun(2, hl, ll);
    chk("R10 ch2 high run on source 2", hl, 6); chk("R10 ch2 low run on source 2", ll, 3);

    // R4: new high count shows only from a later period
    wr(8'h10, 32'd0);
    measureRun(0, hl, ll);
    measureRun(0, hl, ll);
    chk("R4 ch0 new high run", hl, 1); chk("R4 ch0 low run kept", ll, 2);

    // R5: bypass ch1 on source 1
    selImg = selImg | (32'd1 << 3) | (32'd1 << 22);
    wr(8'h00, selImg);
    gateImg = 32'b111;
    wr(8'h0C, gateImg); wr(8'h08, gateImg); wr(8'h04, gateImg);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R5 bypass follows source", 32'(pwmOut[1]), 32'(srcTick[1]));
    end

    // R6: index write ignored while pre-enabled, bypass bit still written
    wr(8'h00, (32'd3 << 3) | (32'd2 << 6));
    rd(8'h00, rv);
    chk("R6 select locked, bypass cleared", rv, (32'd1 << 3) | (32'd2 << 6));

    // R7: pre-divider gate pauses ch0
    wr(8'h08, 32'b110);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R7 paused channel low", 32'(pwmOut[0]), 32'h0);
    end
    wr(8'h08, 32'b111);
    repeat (10) @(negedge clk);

    // R8: post-divider gate holds ch2 at start
    wr(8'h0C, 32'b011);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R8 frozen channel low", 32'(pwmOut[2]), 32'h0);
    end
    wr(8'h0C, 32'b111);
    chk("R8 first cycle after release is high", 32'(pwmOut[2]), 32'h1);

    // R9: output enable cleared on ch0
    wr(8'h04, 32'b110);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R9 output disabled low", 32'(pwmOut[0]), 32'h0);
    end
    wr(8'h04, 32'b111);

    // R3 out-of-range index on ch4, R10 random source on ch3
    selImg = (32'd1 << 3) | (32'd2 << 6) | (32'd3 << 9) | (32'd7 << 12);
    wr(8'h00, selImg);
    wr(8'h28, 32'd2); wr(8'h2C, 32'd3);
    wr(8'h30, 32'd0); wr(8'h34, 32'd0);
    gateImg = 32'b11111;
    wr(8'h0C, gateImg); wr(8'h08, gateImg); wr(8'h04, gateImg);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R3 no ticks from index 7", 32'(pwmOut[4]), 32'h1);
    end
    repeat (150) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      bad++;
      $display("FAIL watchdog expired: act=running exp=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule